// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block takes bytes off an asynchronous serial line. A 16x oversampling tick, made by a baud divider outside the block, paces all of its timing. While the line is quiet the block samples it on every tick and waits for a low level. When it sees one, it counts half a bit period and samples the line again. If the line is still low, that point is the centre of the start bit. From there the block makes a bit-rate strobe every sixteen ticks, so every later bit is sampled at its centre.

Each sample enters a three-part chain: a stop stage, then a parity stage, then an 8-bit data shift register that shifts right. At the start of a frame the whole chain is filled with ones. The start bit's zero is therefore a marker, and the frame is almost complete when that zero reaches the lowest bit of the data register. The next strobe, at the stop-bit centre, completes the frame. One clock later the block checks the frame, copies the byte into a holding register, raises the ready flag and returns to idle. A host clears the ready flag with a read strobe.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_ready`, `err_parity`, `err_frame` and `err_overrun` are 0 and `rx_data` is 0x00.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, one parity bit and one high stop bit. When a frame completes, its byte appears on `rx_data` and `rx_ready` becomes 1.
- R3: `rx_in` passes through a two-flop synchroniser. A start is seen at the first tick on which the synchronised line is low. The start bit is confirmed by a low sample 8 ticks later, and every later bit is sampled 16 ticks after the previous one.
- R4: If the sample taken 8 ticks after a start is seen is high, the start is treated as a glitch and the block returns to idle. `rx_ready` and `rx_data` are left unchanged.
- R5: Parity is odd. `err_parity` is 1 for a byte whose eight data bits and parity bit hold an even number of ones, and 0 otherwise. The flag is updated with every received byte.
- R6: `err_frame` is 1 for a byte whose sampled stop bit was 0, and 0 otherwise. The flag is updated with every received byte.
- R7: `err_overrun` is 1 for a byte that completes while `rx_ready` is still set and no read strobe is given in the same cycle. The new byte replaces the old one in the holding register.
- R8: A one-cycle `rd_stb` clears `rx_ready` on the next clock and leaves `rx_data` unchanged.
- R9: The bit-rate strobe runs only while a frame is in progress. The block is idle one clock after the byte is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-clock pulse at sixteen times the bit rate |
| rx_in | input | 1 | Serial line, asynchronous to clk |
| rd_stb | input | 1 | Read strobe; clears the ready flag |
| rx_data | output | 8 | Holding register with the last received byte |
| rx_ready | output | 1 | A byte is waiting to be read |
| err_parity | output | 1 | Odd-parity check failed on the held byte |
| err_frame | output | 1 | Stop bit of the held byte was sampled low |
| err_overrun | output | 1 | The held byte overwrote an unread byte |

## Verification
The bench sends all-zero, all-one and alternating bytes, plus bytes with the high and low halves filled. These show whether bit order, the marker detection and the mapping from the chain to the holding register are correct, since each shifted bit lands in its own position. Frames with a flipped parity bit or a low stop bit show whether each error flag follows its own check and whether the flag clears on the next good byte. Two frames sent back to back with no read show whether overrun is reported. A short low pulse on an idle line shows whether the centre check rejects a false start and leaves the held byte and the ready flag untouched.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_HUNT  = 2'd1,
    S_SHIFT = 2'd2,
    S_DONE  = 2'd3
  } rx_state_t;

  // 1 when the data bits plus the parity bit do not hold an odd count of ones
  function automatic logic odd_fail(input logic [7:0] data, input logic par);
    return ~(^{data, par});
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_in};
  end

  assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick16,
  input  logic      rx_s,
  input  logic      marker_at0,
  output rx_state_t state,
  output logic      start_det,
  output logic      bit_tick,
  output logic      last_tick,
  output logic      glitch
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;

  logic [CW-1:0] cnt_q;
  logic          at_centre, at_wrap;

  assign at_centre = (state == S_HUNT) && tick16 && (cnt_q == CW'(HALF - 1));
  assign at_wrap   = (state == S_SHIFT) && tick16 && (cnt_q == CW'(OVERSAMPLE - 1));
  assign start_det = (state == S_IDLE) && tick16 && !rx_s;
  assign glitch    = at_centre && rx_s;
  assign bit_tick  = (at_centre && !rx_s) || at_wrap;
  assign last_tick = at_wrap && marker_at0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_det) begin
          state <= S_HUNT;
          cnt_q <= '0;
        end
        S_HUNT: if (tick16) begin
          if (at_centre) begin
            cnt_q <= '0;
            state <= rx_s ? S_IDLE : S_SHIFT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_SHIFT: if (tick16) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_tick) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: a high centre sample abandons the start
  a_r4_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> state == S_IDLE);
  // R9: the stop strobe ends shifting, then idle follows one clock later
  a_r9_last_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> state == S_DONE);
  a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DONE |=> state == S_IDLE);
endmodule

// File: rtl/rx_shift_chain.sv
module rx_shift_chain #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic              bit_tick,
  input  logic              rx_s,
  output logic [DATA_W-1:0] rsr,
  output logic              par_q,
  output logic              stop_q,
  output logic              acc_q,
  output logic              marker_at0
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsr    <= '1;
      par_q  <= 1'b1;
      stop_q <= 1'b1;
      acc_q  <= 1'b0;
    end else if (preset) begin
      rsr    <= '1;
      par_q  <= 1'b1;
      stop_q <= 1'b1;
      acc_q  <= 1'b0;
    end else if (bit_tick) begin
      rsr    <= {par_q, rsr[DATA_W-1:1]};
      par_q  <= stop_q;
      stop_q <= rx_s;
      acc_q  <= acc_q ^ stop_q;
    end
  end

  assign marker_at0 = ~rsr[0];

  // R3: the start marker cannot sit at bit 0 right after a preset
  a_r3_preset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> !marker_at0);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic              rx_s;
  rx_state_t         state;
  logic              start_det, bit_tick, last_tick, glitch;
  logic [DATA_W-1:0] rsr;
  logic              par_q, stop_q, acc_q, marker_at0;
  logic              load;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rx_s));

  rx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_s(rx_s),
    .marker_at0(marker_at0), .state(state), .start_det(start_det),
    .bit_tick(bit_tick), .last_tick(last_tick), .glitch(glitch));

  rx_shift_chain #(.DATA_W(DATA_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .preset(start_det), .bit_tick(bit_tick),
    .rx_s(rx_s), .rsr(rsr), .par_q(par_q), .stop_q(stop_q),
    .acc_q(acc_q), .marker_at0(marker_at0));

  assign load = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else if (load) begin
      rx_data     <= rsr;
      rx_ready    <= 1'b1;
      err_parity  <= acc_q;
      err_frame   <= ~stop_q;
      err_overrun <= rx_ready & ~rd_stb;
    end else if (rd_stb) begin
      rx_ready    <= 1'b0;
    end
  end

  // R2: a completed frame raises ready
  a_r2_ready_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rx_ready);
  // R5: running accumulator agrees with a direct parity check of the byte
  a_r5_parity_match: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> err_parity == odd_fail($past(rsr), $past(par_q)));
  // R6: framing flag follows the sampled stop bit
  a_r6_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> err_frame == !$past(stop_q));
  // R7: overrun reflects an unread byte at load time
  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> err_overrun == $past(rx_ready && !rd_stb));
  // R8: a read without a load clears ready and keeps the data
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !load) |=> (!rx_ready && $stable(rx_data)));
endmodule

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic       rd_stb = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun;

  int checks = 0;
  int failures = 0;
  logic exp_ready = 1'b0;
  logic done = 1'b0;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       ovr;
  } exp_t;
  exp_t sb_q[$];
  event frame_sent;

  always #2.5 clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == TICK_DIV - 1);
  end

  uart_rx_core dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in), .rd_stb(rd_stb),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk) rx_in = b;
    repeat (BIT_CLKS) @(posedge clk);
  endtask

  // driver: pushes expected result, then sends the frame
  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    exp_t e;
    logic p;
    p = ~(^d) ^ bad_par;
    e.data = d;
    e.perr = bad_par;
    e.ferr = bad_stop;
    e.ovr  = exp_ready;
    sb_q.push_back(e);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(p);
    drive_bit(~bad_stop);
    exp_ready = 1'b1;
    ->frame_sent;
    drive_bit(1'b1);
  endtask

  task automatic do_read();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    exp_ready = 1'b0;
    @(negedge clk);
    chk("R8 ready cleared", {31'd0, rx_ready}, 32'd0);
  endtask

  // monitor: compares outputs against the queue head
  initial begin
    forever begin
      @(frame_sent);
      @(negedge clk);
      if (sb_q.size() == 0) begin
        chk("R2 scoreboard empty", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R2 data", {24'd0, rx_data}, {24'd0, e.data});
        chk("R2 ready", {31'd0, rx_ready}, 32'd1);
        chk("R5 parity flag", {31'd0, err_parity}, {31'd0, e.perr});
        chk("R6 frame flag", {31'd0, err_frame}, {31'd0, e.ferr});
        chk("R7 overrun flag", {31'd0, err_overrun}, {31'd0, e.ovr});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 ready", {31'd0, rx_ready}, 32'd0);
    chk("R1 data", {24'd0, rx_data}, 32'd0);
    chk("R1 flags", {29'd0, err_parity, err_frame, err_overrun}, 32'd0);
    rst_n = 1'b1;
    repeat (BIT_CLKS) @(posedge clk);

    // R2 R3: bit order and centre sampling with varied patterns
    send(8'h00, 1'b0, 1'b0); do_read();
    send(8'hFF, 1'b0, 1'b0); do_read();
    send(8'h55, 1'b0, 1'b0); do_read();
    send(8'hA5, 1'b0, 1'b0); do_read();
    send(8'h0F, 1'b0, 1'b0); do_read();
    send(8'hF0, 1'b0, 1'b0); do_read();
    // R5: bad parity, then cleared by a good byte
    send(8'h3C, 1'b1, 1'b0); do_read();
    send(8'h3C, 1'b0, 1'b0); do_read();
    // R6: low stop bit, then cleared
    send(8'h81, 1'b0, 1'b1); do_read();
    send(8'h7E, 1'b0, 1'b0); do_read();
    // R7: two bytes with no read in between
    send(8'h12, 1'b0, 1'b0);
    send(8'h34, 1'b0, 1'b0); do_read();
    send(8'h56, 1'b0, 1'b0);
    // R8: read keeps data
    do_read();
    chk("R8 data kept", {24'd0, rx_data}, 32'h56);
    // R4: short low pulse is rejected
    @(negedge clk) rx_in = 1'b0;
    repeat (3 * TICK_DIV) @(posedge clk);
    @(negedge clk) rx_in = 1'b1;
    repeat (3 * BIT_CLKS) @(posedge clk);
    @(negedge clk);
    chk("R4 ready untouched", {31'd0, rx_ready}, 32'd0);
    chk("R4 data untouched", {24'd0, rx_data}, 32'h56);
    // R4 R9: a full frame still works after the rejected start
    send(8'hC3, 1'b0, 1'b0); do_read();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule